// File: doc/BRIEF.md
# Reloadable Fixed-Point Biquad Compensator

This block is one second-order recursive filter section for a digital power-converter control loop. Each accepted sample strobe takes a 12-bit converter reading and produces one new 16-bit loop output. The output is computed as b0·x[n] + b1·x[n−1] + b2·x[n−2] − a1·y[n−1] − a2·y[n−2]. The leading denominator term is normalised to one and is not stored. One section can hold a complete compensator, for example an integrator together with a lead-lag pair.

The five coefficients are written at run time into a holding set. A separate apply pulse copies the holding set into the working set. The copy never lands while a computation is in flight, so every output uses one consistent set of coefficients. Products are kept at full width and summed in a wide accumulator. The sum is then rounded back to the data format and clamped to the 16-bit range, so it never wraps around. A clear input empties the history without touching the coefficients.

Top module: `biquad_comp`

## Requirements
- R1: The ADC code is taken as signed two's complement and placed in the upper 12 bits of the 16-bit input word. The lower 4 bits are zero, so x = code·16, read as signed Q1.15.
- R2: The output is y = (b0·x0 + b1·x1 + b2·x2 − a1·y1 − a2·y2) / 2^14. The coefficients are signed Q2.14. x1 and x2 are the two previous accepted inputs. y1 and y2 are the two previous outputs, taken after rounding and clamping.
- R3: Rounding is to nearest, with ties toward positive infinity: floor((sum + 8192) / 16384).
- R4: A rounded result above 32767 is output as 32767, and one below −32768 is output as −32768.
- R5: A strobe is accepted at a rising edge. y_vld is then high for exactly one cycle after the next rising edge, and y_out changes only at that edge (or on clear).
- R6: A strobe at the edge just after an accepted strobe is dropped. It produces no output and does not enter the history.
- R7: A coefficient write selects its target with cf_sel (0=b0, 1=b1, 2=b2, 3=a1, 4=a2). It changes only the holding set and has no effect on results until cf_apply.
- R8: An apply that arrives while a computation is in flight is held back. The computation in flight uses the old set, and the next sample uses the new one.
- R9: clr zeroes the input and output history and y_out, and cancels a computation in flight (no y_vld). Coefficients are kept.
- R10: After reset y_out=0, y_vld=0 and all coefficients are zero, so a sample yields 0.
- R11: Writes with cf_sel values 5, 6 or 7 change nothing.
- R12: With b0=b1, a1=−1.0 and the other coefficients zero, the section integrates. A constant input ramps the output until it holds at the clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous history clear |
| smp_vld | input | 1 | Sample strobe |
| smp_adc | input | 12 | Signed ADC code |
| cf_we | input | 1 | Coefficient write enable |
| cf_sel | input | 3 | Coefficient select |
| cf_data | input | 16 | Coefficient value, signed Q2.14 |
| cf_apply | input | 1 | Copy holding set to working set |
| y_vld | output | 1 | Output valid pulse |
| y_out | output | 16 | Filter output, signed Q1.15 |

## Verification
The hardest case to reach from the ports is an apply pulse that lands during the single cycle in which a computation is in flight. The stimulus creates it by raising cf_apply on the cycle right after an accepted strobe. The bench then checks that the result still follows the old coefficients and that the following sample follows the new ones. The bench also drives two back-to-back strobes and issues a clear in the busy cycle. A sample taken afterwards exposes any history corruption through the feedback and feedforward terms.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
    localparam int NUM_COEF = 5;
    localparam int NUM_FWD  = 3;
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        CF_B0 = 3'd0,
        CF_B1 = 3'd1,
        CF_B2 = 3'd2,
        CF_A1 = 3'd3,
        CF_A2 = 3'd4
    } coef_sel_e;
endpackage

// File: rtl/biquad_coef_bank.sv
module biquad_coef_bank #(
    parameter int CW    = 16,
    parameter int NC    = biquad_pkg::NUM_COEF,
    parameter int SEL_W = biquad_pkg::SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [CW-1:0]          wr_data,
    input  logic                   xfer,
    output logic [NC-1:0][CW-1:0]  active_o
);
    typedef struct packed {
        logic [NC-1:0][CW-1:0] hold;
        logic [NC-1:0][CW-1:0] work;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NC-1:0] hit;

    // one write-decode line per coefficient slot
    for (genvar i = 0; i < NC; i++) begin : g_dec
        assign hit[i] = wr_en && (wr_sel == SEL_W'(i));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NC; i++) begin
            if (hit[i]) bank_d.hold[i] = wr_data;
        end
        if (xfer) bank_d.work = bank_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign active_o = bank_q.work;

    // working set moves only on a transfer (R7)
    assert_work_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(bank_q.work));
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int ACCW = 36,
    parameter int NC   = biquad_pkg::NUM_COEF,
    parameter int NFWD = biquad_pkg::NUM_FWD
) (
    input  logic [NC-1:0][DW-1:0] taps,
    input  logic [NC-1:0][CW-1:0] coefs,
    output logic [DW-1:0]         y,
    output logic                  sat
);
    localparam int PW = DW + CW;
    localparam logic [ACCW-1:0] HALF = {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

    logic signed [PW-1:0]   prod [NC];
    logic signed [ACCW-1:0] term [NC];
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] biased;
    logic signed [ACCW-1:0] shifted;
    logic [ACCW-DW:0]       top;

    for (genvar i = 0; i < NC; i++) begin : g_tap
        assign prod[i] = $signed(taps[i]) * $signed(coefs[i]);
        if (i < NFWD) begin : g_fwd
            assign term[i] = $signed({{(ACCW-PW){prod[i][PW-1]}}, prod[i]});
        end else begin : g_fbk
            assign term[i] = -$signed({{(ACCW-PW){prod[i][PW-1]}}, prod[i]});
        end
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NC; i++) begin
            acc = acc + term[i];
        end
        biased  = acc + $signed(HALF);
        shifted = biased >>> FRAC;
        top     = shifted[ACCW-1:DW-1];
        sat     = !((&top) || (~|top));
        if (sat) y = shifted[ACCW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else     y = shifted[DW-1:0];
    end
endmodule

// File: rtl/biquad_comp.sv
module biquad_comp #(
    parameter int AW   = 12,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int ACCW = 36
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          smp_vld,
    input  logic [AW-1:0]                 smp_adc,
    input  logic                          cf_we,
    input  logic [biquad_pkg::SEL_W-1:0]  cf_sel,
    input  logic [CW-1:0]                 cf_data,
    input  logic                          cf_apply,
    output logic                          y_vld,
    output logic [DW-1:0]                 y_out
);
    import biquad_pkg::*;

    localparam int PAD = DW - AW;
    localparam logic [DW-1:0] Y_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] Y_MIN = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic          busy;
        logic          pend;
        logic          vld;
        logic [DW-1:0] x0;
        logic [DW-1:0] x1;
        logic [DW-1:0] x2;
        logic [DW-1:0] y1;
        logic [DW-1:0] y2;
        logic [DW-1:0] yo;
    } st_t;

    st_t st_d, st_q;

    logic                        xfer;
    logic [NUM_COEF-1:0][CW-1:0] coef_w;
    logic [NUM_COEF-1:0][DW-1:0] taps;
    logic [DW-1:0]               mac_y;
    logic                        mac_sat;

    biquad_coef_bank #(.CW(CW), .NC(NUM_COEF), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cf_we),
        .wr_sel   (cf_sel),
        .wr_data  (cf_data),
        .xfer     (xfer),
        .active_o (coef_w)
    );

    assign taps = {st_q.y2, st_q.y1, st_q.x2, st_q.x1, st_q.x0};

    biquad_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .ACCW(ACCW),
                 .NC(NUM_COEF), .NFWD(NUM_FWD)) u_mac (
        .taps  (taps),
        .coefs (coef_w),
        .y     (mac_y),
        .sat   (mac_sat)
    );

    // a pending or fresh apply lands only when nothing is in flight
    assign xfer = (cf_apply || st_q.pend) && !st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.pend = (cf_apply || st_q.pend) && st_q.busy;
        if (st_q.busy) begin
            st_d.x2   = st_q.x1;
            st_d.x1   = st_q.x0;
            st_d.y2   = st_q.y1;
            st_d.y1   = mac_y;
            st_d.yo   = mac_y;
            st_d.vld  = 1'b1;
            st_d.busy = 1'b0;
        end else if (smp_vld) begin
            st_d.x0   = {smp_adc, {PAD{1'b0}}};
            st_d.busy = 1'b1;
        end
        if (clr) begin
            st_d.busy = 1'b0;
            st_d.vld  = 1'b0;
            st_d.x0   = '0;
            st_d.x1   = '0;
            st_d.x2   = '0;
            st_d.y1   = '0;
            st_d.y2   = '0;
            st_d.yo   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_vld = st_q.vld;
    assign y_out = st_q.yo;

    assert_vld_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld |=> !y_vld);
    assert_vld_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        y_vld |-> $past(st_q.busy));
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!y_vld && !$past(clr)) |-> $stable(y_out));
    assert_busy_from_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> $past(smp_vld));
    assert_busy_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !st_q.busy);
    assert_coef_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(coef_w));
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!y_vld && y_out == '0));
    assert_sat_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && mac_sat && !clr) |=> (y_out == Y_MAX || y_out == Y_MIN));
endmodule

// File: tb/sim_biquad_comp.sv
`timescale 1ns/1ps
module sim_biquad_comp;
    import biquad_pkg::*;

    localparam time CYC = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        smp_vld = 1'b0;
    logic [11:0] smp_adc = '0;
    logic        cf_we = 1'b0;
    logic [2:0]  cf_sel = '0;
    logic [15:0] cf_data = '0;
    logic        cf_apply = 1'b0;
    logic        y_vld;
    logic [15:0] y_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    longint mc [5];
    longint ms [5];
    longint bx1, bx2, by1, by2;

    always #(CYC/2) clk = ~clk;

    biquad_comp u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld), .smp_adc(smp_adc),
        .cf_we(cf_we), .cf_sel(cf_sel), .cf_data(cf_data), .cf_apply(cf_apply),
        .y_vld(y_vld), .y_out(y_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint rnd_sat(input longint s);
        longint t;
        t = (s + 64'sd8192) >>> 14;
        if (t > 32767)  t = 32767;
        if (t < -32768) t = -32768;
        return t;
    endfunction

    function automatic longint model_step(input logic [11:0] adc);
        longint x, y;
        x = longint'($signed(adc)) * 16;
        y = rnd_sat(mc[0]*x + mc[1]*bx1 + mc[2]*bx2 - mc[3]*by1 - mc[4]*by2);
        bx2 = bx1; bx1 = x; by2 = by1; by1 = y;
        return y;
    endfunction

    function automatic void model_clear();
        bx1 = 0; bx2 = 0; by1 = 0; by2 = 0;
    endfunction

    function automatic longint yo();
        return longint'($signed(y_out));
    endfunction

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        cf_we = 1'b1; cf_sel = 3'(sel); cf_data = 16'(val);
        if (sel < 5) ms[sel] = longint'($signed(16'(val)));
        @(negedge clk);
        cf_we = 1'b0;
    endtask

    task automatic apply();
        @(negedge clk);
        cf_apply = 1'b1;
        @(negedge clk);
        cf_apply = 1'b0;
        for (int i = 0; i < 5; i++) mc[i] = ms[i];
    endtask

    task automatic set5(input int b0, input int b1, input int b2, input int a1, input int a2);
        wr(0, b0); wr(1, b1); wr(2, b2); wr(3, a1); wr(4, a2);
        apply();
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
    endtask

    task automatic sample(input string req, input logic [11:0] adc);
        longint e;
        @(negedge clk);
        smp_vld = 1'b1; smp_adc = adc;
        @(negedge clk);
        smp_vld = 1'b0;
        check({req, " R5 no early valid"}, longint'(y_vld), 0);
        @(negedge clk);
        e = model_step(adc);
        check({req, " R5 valid"}, longint'(y_vld), 1);
        check(req, yo(), e);
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] lfsr;
        longint e;
        for (int i = 0; i < 5; i++) begin mc[i] = 0; ms[i] = 0; end
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset vld", longint'(y_vld), 0);
        check("R10 reset out", yo(), 0);
        sample("R10 zero coefs", 12'h3A5);

        // R1: identity, every ADC code
        set5(16384, 0, 0, 0, 0);
        for (int c = 0; c < 4096; c++) begin
            sample("R1 alignment", 12'(c));
        end

        // R12 / R4: integrator ramps up then down into both clamps
        do_clear();
        set5(4096, 4096, 0, -16384, 0);
        for (int k = 0; k < 40; k++) sample("R12 integrate up", 12'h100);
        check("R4 positive clamp", yo(), 32767);
        for (int k = 0; k < 80; k++) sample("R12 integrate down", 12'hF00);
        check("R4 negative clamp", yo(), -32768);

        // R2: example compensator, pseudo-random inputs
        do_clear();
        set5(4096, -11878, -3994, -32309, 15892);
        lfsr = 12'hACE;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[10:0], lfsr[11] ^ lfsr[10] ^ lfsr[9] ^ lfsr[3]};
            sample("R2 compensator", lfsr >> 4);
        end

        // R3: small coefficients make rounding visible, all codes
        do_clear();
        set5(1, 3, -5, 100, -7);
        for (int c = 0; c < 4096; c++) sample("R3 rounding", 12'(c));

        // R7: holding-set write without apply
        do_clear();
        set5(16384, 0, 0, 0, 0);
        wr(0, 8192);
        sample("R7 no effect before apply", 12'h200);
        apply();
        sample("R7 effect after apply", 12'h200);

        // R11: out-of-range selects
        wr(5, 32767); wr(6, -1); wr(7, 12345);
        apply();
        sample("R11 bad select ignored", 12'h7FF);

        // R8: apply lands during the busy cycle
        do_clear();
        set5(16384, 0, 0, 0, 0);
        wr(0, 4096);
        @(negedge clk);
        smp_vld = 1'b1; smp_adc = 12'h400;
        @(negedge clk);
        smp_vld = 1'b0; cf_apply = 1'b1;
        @(negedge clk);
        cf_apply = 1'b0;
        e = model_step(12'h400);
        check("R8 valid", longint'(y_vld), 1);
        check("R8 old coefs in flight", yo(), e);
        for (int i = 0; i < 5; i++) mc[i] = ms[i];
        sample("R8 new coefs next", 12'h400);

        // R6: back-to-back strobes, second dropped
        do_clear();
        set5(16384, 16384, 0, 0, 0);
        @(negedge clk);
        smp_vld = 1'b1; smp_adc = 12'h010;
        @(negedge clk);
        smp_adc = 12'h300;
        @(negedge clk);
        smp_vld = 1'b0;
        e = model_step(12'h010);
        check("R6 first valid", longint'(y_vld), 1);
        check("R6 first result", yo(), e);
        @(negedge clk);
        check("R6 no second valid", longint'(y_vld), 0);
        sample("R6 history intact", 12'h020);

        // R9: clear during busy cycle
        set5(4096, 4096, 0, -16384, 0);
        for (int k = 0; k < 4; k++) sample("R9 prefill", 12'h100);
        @(negedge clk);
        smp_vld = 1'b1; smp_adc = 12'h100;
        @(negedge clk);
        smp_vld = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        check("R9 cancelled valid", longint'(y_vld), 0);
        check("R9 cleared out", yo(), 0);
        sample("R9 empty history", 12'h100);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule